// File: doc/BRIEF.md
# Saturating Lattice-Ladder IIR Filter Engine

This block is a recursive all-pole filter built as a chain of lattice stages with a ladder tap network on top. It takes one signed Q1.31 sample per transaction. The sample passes through the lattice stages one per clock. Each stage uses a reflection coefficient to update a forward value and a backward value, and both updates saturate. A 64-bit accumulator sums the backward values, each weighted by a ladder coefficient. The accumulator is then scaled back down to one Q1.31 output sample.

The delayed backward values live in a bank of state registers inside the block. After every sample the bank moves by one stage position. Both coefficient arrays are loaded through a plain write port while the engine is idle. Samples arrive on a valid/ready handshake. Each result leaves as a one-cycle valid pulse.

Top module: `lattice_iir_engine`

## Requirements
- R1: The stages run in index order 0 to N-1, and the forward value seen by stage 0 is the input sample. Stage i computes f_next = sat(f_cur - P(g_old[i], k[i])), where P(a,b) is bits [62:31] of the full 64-bit signed product a*b and g_old[i] is state slot i. Each f_next becomes f_cur for the following stage.
- R2: Stage i computes g_new = sat(g_old[i] + P(f_next, k[i])). Here sat clamps to the signed range 0x80000000..0x7FFFFFFF.
- R3: The accumulator starts from zero for each sample. It adds g_new*v[i] for every stage i and then adds f_final*v[N]. The output is bits [62:31] of the result with no rounding, so negative fractions round toward minus infinity.
- R4: The accumulator is 64 bits wide. When a sum overflows it wraps modulo 2^64 and is never clamped.
- R5: After each sample, state slot i takes the g_new of stage i+1 for i < N-1, and slot N-1 takes f_final. The g_new of stage 0 contributes to the output only and is not kept.
- R6: A synchronous reset clears the state slots, the accumulator and both coefficient arrays. After reset, in_ready is 1, out_valid is 0 and out_data is 0.
- R7: A sample is accepted on a clock edge where in_valid and in_ready are both 1. in_ready is then 0 until out_valid has been seen. out_valid is 1 for exactly one cycle, which is the cycle that follows N+1 further edges after the accepting edge. in_ready is 1 again in the next cycle.
- R8: A write with cfg_we=1 and cfg_sel=0 loads reflection coefficient k[cfg_addr], with valid addresses 0..N-1. A write with cfg_sel=1 loads ladder coefficient v[cfg_addr], with valid addresses 0..N. A write to an address outside these ranges, or a write while in_ready is 0, has no effect.
- R9: in_valid is ignored while in_ready is 0. A busy engine neither takes the new sample nor lets in_data disturb the computation in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample offered |
| in_ready | output | 1 | Engine idle and able to take a sample |
| in_data | input | DW | Input sample, signed Q1.31 |
| out_valid | output | 1 | One-cycle pulse marking a result |
| out_data | output | DW | Output sample, signed Q1.31 |
| cfg_we | input | 1 | Coefficient write strobe |
| cfg_sel | input | 1 | 0 selects reflection array, 1 selects ladder array |
| cfg_addr | input | clog2(NSTAGE+1) | Coefficient index |
| cfg_data | input | DW | Coefficient value, signed Q1.31 |

## Verification
Two corner cases are hard to reach from the ports. The first is an accumulator that wraps. The second is a saturating stage whose operand comes from state. Neither can be set directly. The state first has to be filled with values near full scale by a run of extreme samples. The bench therefore does this in phases. One phase sets the reflection coefficients to zero so the lattice becomes a delay line, and feeds in full-scale samples. The ladder coefficients are then set near one, which makes six near-2^62 products overflow the sum. Another phase sets the reflection coefficients to full magnitude and alternates input signs, which drives both stage updates into their clamps. The rotation of the state is observed through the output by placing a single non-zero ladder tap on slot 0.

// File: rtl/lattice_iir_pkg.sv
package lattice_iir_pkg;

   // Sequencer phases of the engine
   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_STAGE = 2'd1,
      PH_TAIL  = 2'd2,
      PH_DONE  = 2'd3
   } lat_phase_e;

endpackage

// File: rtl/lat_stage_alu.sv
// One lattice stage: saturating forward and backward updates.
module lat_stage_alu #(
   parameter int DW = 32
) (
   input  logic signed [DW-1:0] f_cur,
   input  logic signed [DW-1:0] g_old,
   input  logic signed [DW-1:0] coef_k,
   output logic signed [DW-1:0] f_next,
   output logic signed [DW-1:0] g_new
);
   localparam int PW = 2 * DW;
   localparam logic signed [DW-1:0] SMAX = {1'b0, {(DW-1){1'b1}}};
   localparam logic signed [DW-1:0] SMIN = {1'b1, {(DW-1){1'b0}}};

   function automatic logic signed [DW-1:0] clamp(input logic signed [DW:0] s);
      if (s[DW] != s[DW-1]) return s[DW] ? SMIN : SMAX;
      return s[DW-1:0];
   endfunction

   logic signed [PW-1:0] p_fb;
   logic signed [PW-1:0] p_ff;
   logic signed [DW-1:0] t_fb;
   logic signed [DW-1:0] t_ff;

   always_comb begin
      p_fb   = PW'(g_old) * PW'(coef_k);
      t_fb   = DW'(p_fb >>> (DW-1));
      f_next = clamp((DW+1)'(f_cur) - (DW+1)'(t_fb));
      p_ff   = PW'(f_next) * PW'(coef_k);
      t_ff   = DW'(p_ff >>> (DW-1));
      g_new  = clamp((DW+1)'(g_old) + (DW+1)'(t_ff));
   end

endmodule

// File: rtl/lat_coef_bank.sv
// Reflection (NSTAGE entries) and ladder (NSTAGE+1 entries) coefficient registers.
module lat_coef_bank #(
   parameter int NSTAGE = 8,
   parameter int DW     = 32,
   parameter int AW     = 4
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 wr_en,
   input  logic                 wr_sel,
   input  logic [AW-1:0]        wr_addr,
   input  logic [DW-1:0]        wr_data,
   input  logic [AW-1:0]        rd_idx,
   output logic signed [DW-1:0] k_rd,
   output logic signed [DW-1:0] v_rd
);
   logic signed [DW-1:0] k_mem [NSTAGE];
   logic signed [DW-1:0] v_mem [NSTAGE+1];

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int j = 0; j < NSTAGE; j++) k_mem[j] <= '0;
         for (int j = 0; j <= NSTAGE; j++) v_mem[j] <= '0;
      end else if (wr_en) begin
         for (int j = 0; j < NSTAGE; j++)
            if (!wr_sel && wr_addr == AW'(j)) k_mem[j] <= wr_data;
         for (int j = 0; j <= NSTAGE; j++)
            if (wr_sel && wr_addr == AW'(j)) v_mem[j] <= wr_data;
      end
   end

   always_comb begin
      k_rd = '0;
      v_rd = '0;
      for (int j = 0; j < NSTAGE; j++)
         if (rd_idx == AW'(j)) k_rd = k_mem[j];
      for (int j = 0; j <= NSTAGE; j++)
         if (rd_idx == AW'(j)) v_rd = v_mem[j];
   end

endmodule

// File: rtl/lat_state_regs.sv
// Delayed backward values; rotated by one slot per processed sample.
module lat_state_regs #(
   parameter int NSTAGE = 8,
   parameter int DW     = 32,
   parameter int AW     = 4
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 shift_we,
   input  logic [AW-1:0]        stage_idx,
   input  logic signed [DW-1:0] g_in,
   input  logic                 tail_we,
   input  logic signed [DW-1:0] f_in,
   output logic signed [DW-1:0] rd_val
);
   logic signed [DW-1:0] st [NSTAGE];
   logic [NSTAGE-1:0]    hit;

   generate
      if (NSTAGE > 1) begin : g_chain
         // stage j+1 writes its backward output into slot j
         always_comb begin
            hit = '0;
            for (int j = 0; j < NSTAGE-1; j++)
               hit[j] = shift_we && (stage_idx == AW'(j+1));
         end
      end else begin : g_single
         assign hit = '0;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int j = 0; j < NSTAGE; j++) st[j] <= '0;
      end else begin
         for (int j = 0; j < NSTAGE; j++) begin
            if (tail_we && j == NSTAGE-1) st[j] <= f_in;
            else if (hit[j])              st[j] <= g_in;
         end
      end
   end

   always_comb begin
      rd_val = '0;
      for (int j = 0; j < NSTAGE; j++)
         if (stage_idx == AW'(j)) rd_val = st[j];
   end

endmodule

// File: rtl/lattice_iir_engine.sv
module lattice_iir_engine
   import lattice_iir_pkg::*;
#(
   parameter int NSTAGE = 8,
   parameter int DW     = 32
) (
   input  logic                        clk,
   input  logic                        rst,
   input  logic                        in_valid,
   output logic                        in_ready,
   input  logic [DW-1:0]               in_data,
   output logic                        out_valid,
   output logic [DW-1:0]               out_data,
   input  logic                        cfg_we,
   input  logic                        cfg_sel,
   input  logic [$clog2(NSTAGE+1)-1:0] cfg_addr,
   input  logic [DW-1:0]               cfg_data
);
   localparam int AW  = $clog2(NSTAGE + 1);
   localparam int ACW = 2 * DW;

   generate
      if (NSTAGE < 1 || NSTAGE > 32) begin : g_bad_stages
         $error("NSTAGE must lie in 1..32");
      end
      if (DW < 8) begin : g_bad_width
         $error("DW must be at least 8");
      end
   endgenerate

   lat_phase_e            phase;
   logic [AW-1:0]         idx;
   logic signed [DW-1:0]  f_cur;
   logic signed [ACW-1:0] acc;

   logic signed [DW-1:0]  k_rd, v_rd, g_old, f_nx, g_nx;
   logic                  busy_n;

   assign busy_n = (phase == PH_IDLE);

   lat_coef_bank #(.NSTAGE(NSTAGE), .DW(DW), .AW(AW)) u_coef (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (cfg_we && busy_n),
      .wr_sel  (cfg_sel),
      .wr_addr (cfg_addr),
      .wr_data (cfg_data),
      .rd_idx  (idx),
      .k_rd    (k_rd),
      .v_rd    (v_rd)
   );

   lat_state_regs #(.NSTAGE(NSTAGE), .DW(DW), .AW(AW)) u_state (
      .clk       (clk),
      .rst       (rst),
      .shift_we  (phase == PH_STAGE),
      .stage_idx (idx),
      .g_in      (g_nx),
      .tail_we   (phase == PH_TAIL),
      .f_in      (f_cur),
      .rd_val    (g_old)
   );

   lat_stage_alu #(.DW(DW)) u_alu (
      .f_cur  (f_cur),
      .g_old  (g_old),
      .coef_k (k_rd),
      .f_next (f_nx),
      .g_new  (g_nx)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         phase <= PH_IDLE;
         idx   <= '0;
         f_cur <= '0;
         acc   <= '0;
      end else begin
         case (phase)
            PH_IDLE: begin
               if (in_valid) begin
                  f_cur <= in_data;
                  acc   <= '0;
                  idx   <= '0;
                  phase <= PH_STAGE;
               end
            end
            PH_STAGE: begin
               f_cur <= f_nx;
               acc   <= acc + ACW'(g_nx) * ACW'(v_rd);
               idx   <= idx + AW'(1);
               if (idx == AW'(NSTAGE-1)) phase <= PH_TAIL;
            end
            PH_TAIL: begin
               acc   <= acc + ACW'(f_cur) * ACW'(v_rd);
               phase <= PH_DONE;
            end
            default: phase <= PH_IDLE;
         endcase
      end
   end

   assign in_ready  = busy_n;
   assign out_valid = (phase == PH_DONE);
   assign out_data  = acc[ACW-2:DW-1];

endmodule

// File: rtl/lattice_iir_chk.sv
module lattice_iir_chk #(
   parameter int NSTAGE = 8,
   parameter int DW     = 32
) (
   input logic          clk,
   input logic          rst,
   input logic          in_valid,
   input logic          in_ready,
   input logic          out_valid,
   input logic [DW-1:0] out_data
);
   logic [7:0] lat_cnt;
   logic       rst_q;

   always_ff @(posedge clk) begin
      rst_q <= rst;
      if (rst)                          lat_cnt <= '0;
      else if (in_valid && in_ready)    lat_cnt <= '0;
      else if (!in_ready && lat_cnt != 8'hFF) lat_cnt <= lat_cnt + 8'd1;
   end

   always_ff @(posedge clk) begin
      if (rst_q) begin
         // R6
         reset_idle_chk: assert (in_ready && !out_valid && out_data == '0);
      end
   end

   // R7
   accept_drops_ready_chk: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_ready) |=> !in_ready);

   // R7
   valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      out_valid |=> !out_valid);

   // R7
   ready_after_out_chk: assert property (@(posedge clk) disable iff (rst)
      out_valid |=> in_ready);

   // R7
   latency_chk: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> (lat_cnt == 8'(NSTAGE + 1)));

   // R9
   busy_holds_chk: assert property (@(posedge clk) disable iff (rst)
      (!in_ready && !out_valid) |=> !in_ready);

endmodule

bind lattice_iir_engine lattice_iir_chk #(.NSTAGE(NSTAGE), .DW(DW)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .in_valid  (in_valid),
   .in_ready  (in_ready),
   .out_valid (out_valid),
   .out_data  (out_data)
);

// File: tb/lattice_iir_engine_tb_top.sv
module lattice_iir_engine_tb_top;
   localparam int CLK_PER = 10;
   localparam int NST     = 5;
   localparam int DW      = 32;
   localparam int AW      = $clog2(NST + 1);
   localparam longint MAXL = 64'sh7FFFFFFF;
   localparam longint MINL = -64'sh80000000;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          in_valid = 1'b0;
   logic [DW-1:0] in_data = '0;
   logic          cfg_we = 1'b0;
   logic          cfg_sel = 1'b0;
   logic [AW-1:0] cfg_addr = '0;
   logic [DW-1:0] cfg_data = '0;
   logic          in_ready, out_valid;
   logic [DW-1:0] out_data;

   int    checks = 0;
   int    errors = 0;
   string cur_tag = "R6";
   bit    done_flag = 0;
   int    cyc = 0;

   int k_m [NST];
   int v_m [NST+1];
   int st_m[NST];
   bit pending = 0;
   int since = 0;
   int exp_y = 0;

   always #(CLK_PER/2) clk = ~clk;

   lattice_iir_engine #(.NSTAGE(NST), .DW(DW)) dut_i (
      .clk       (clk),
      .rst       (rst),
      .in_valid  (in_valid),
      .in_ready  (in_ready),
      .in_data   (in_data),
      .out_valid (out_valid),
      .out_data  (out_data),
      .cfg_we    (cfg_we),
      .cfg_sel   (cfg_sel),
      .cfg_addr  (cfg_addr),
      .cfg_data  (cfg_data)
   );

   task automatic check(input bit ok, input string tag, input longint act, input longint expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
      end
   endtask

   task automatic finish_up();
      done_flag = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   // ---------------- behavioural reference ----------------
   function automatic int p31(longint p);
      return int'(p >>> 31);
   endfunction

   function automatic int clamp32(longint s);
      longint t = s;
      if (t > MAXL) t = MAXL;
      if (t < MINL) t = MINL;
      return int'(t);
   endfunction

   function automatic int run_model(int x);
      longint acc = 0;
      int f = x;
      int g, fn, gn;
      int nw[NST];
      for (int i = 0; i < NST; i++) begin
         g  = st_m[i];
         fn = clamp32(longint'(f) - longint'(p31(longint'(g) * longint'(k_m[i]))));
         gn = clamp32(longint'(g) + longint'(p31(longint'(fn) * longint'(k_m[i]))));
         acc += longint'(gn) * longint'(v_m[i]);
         nw[i] = gn;
         f = fn;
      end
      acc += longint'(f) * longint'(v_m[NST]);
      for (int i = 0; i < NST-1; i++) st_m[i] = nw[i+1];
      st_m[NST-1] = f;
      return int'(acc >>> 31);
   endfunction

   // ---------------- per-clock comparison ----------------
   always @(negedge clk) begin
      if (rst) begin
         pending = 0;
         since = 0;
         for (int i = 0; i < NST; i++) begin k_m[i] = 0; st_m[i] = 0; end
         for (int i = 0; i <= NST; i++) v_m[i] = 0;
      end else if (!done_flag) begin
         if (pending) begin
            since++;
            if (since == NST + 2) pending = 0;
         end
         // R7: handshake timing every cycle
         check(out_valid == (pending && since == NST + 1), "R7 out_valid",
               longint'(out_valid), longint'(pending && since == NST + 1));
         check(in_ready == !pending, "R7 in_ready", longint'(in_ready), longint'(!pending));
         if (pending && since == NST + 1)
            check($signed(out_data) == exp_y, cur_tag, longint'($signed(out_data)), longint'(exp_y));
         // R8: model coefficient writes
         if (cfg_we && in_ready) begin
            if (!cfg_sel && int'(cfg_addr) < NST)  k_m[cfg_addr] = $signed(cfg_data);
            if (cfg_sel  && int'(cfg_addr) <= NST) v_m[cfg_addr] = $signed(cfg_data);
         end
         if (!pending && in_valid && in_ready) begin
            exp_y = run_model($signed(in_data));
            pending = 1;
            since = -1;
         end
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000 && !done_flag) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
         finish_up();
      end
   end

   // ---------------- stimulus ----------------
   task automatic tick();
      @(posedge clk);
      #2;
   endtask

   task automatic wait_idle();
      while (!in_ready) tick();
      tick();
   endtask

   task automatic wcoef(input bit sel, input int addr, input int val);
      while (!in_ready) tick();
      cfg_we = 1; cfg_sel = sel; cfg_addr = AW'(addr); cfg_data = val;
      tick();
      cfg_we = 0;
   endtask

   task automatic send(input int x);
      while (!in_ready) tick();
      in_valid = 1; in_data = x;
      tick();
      in_valid = 0;
   endtask

   task automatic send_hold(input int x, input int y);
      while (!in_ready) tick();
      in_valid = 1; in_data = x;
      tick();
      in_data = y;
      repeat (NST) tick();
      in_valid = 0;
   endtask

   initial begin
      repeat (3) tick();
      rst = 0;
      // R6: state right after reset
      check(in_ready == 1'b1, "R6 in_ready", longint'(in_ready), 1);
      check(out_valid == 1'b0, "R6 out_valid", longint'(out_valid), 0);
      check(out_data == '0, "R6 out_data", longint'(out_data), 0);

      // R5: zero reflection turns the lattice into a delay line seen through v[0]
      cur_tag = "R5";
      for (int i = 0; i < NST; i++) wcoef(0, i, 0);
      for (int i = 0; i <= NST; i++) wcoef(1, i, (i == 0) ? 32'h40000000 : 0);
      for (int i = 0; i < 12; i++) send((i % 2 == 1) ? -(i+1)*123457 : (i+1)*123457);
      wait_idle();

      // R1: full-magnitude reflection, alternating extreme inputs, forward clamps
      cur_tag = "R1";
      for (int i = 0; i < NST; i++) wcoef(0, i, 32'h7FFFFFFF);
      for (int i = 0; i < NST; i++) wcoef(1, i, 32'h10000000);
      wcoef(1, NST, 32'h7FFFFFFF);
      for (int i = 0; i < 8; i++) send((i % 2 == 1) ? 32'h80000000 : 32'h7FFFFFFF);
      wait_idle();

      // R2: mixed-sign reflection, backward clamps
      cur_tag = "R2";
      for (int i = 0; i < NST; i++) wcoef(0, i, (i % 2 == 1) ? 32'h80000000 : 32'h60000000);
      for (int i = 0; i <= NST; i++) wcoef(1, i, 32'h20000000);
      for (int i = 0; i < 8; i++) send(i * 32'h1F000000);
      wait_idle();

      // R3: small values, truncation toward minus infinity
      cur_tag = "R3";
      for (int i = 0; i < NST; i++) wcoef(0, i, (i + 1) * 32'h0C000000);
      for (int i = 0; i <= NST; i++) wcoef(1, i, (i % 2 == 1) ? -3 : 5);
      for (int i = 0; i < 8; i++) send((i % 3 == 0) ? -(2*i+1) : (3*i+7));
      wait_idle();

      // R4: full-scale state and ladder taps overflow the accumulator
      cur_tag = "R4";
      for (int i = 0; i < NST; i++) wcoef(0, i, 0);
      for (int i = 0; i <= NST; i++) wcoef(1, i, 32'h7FFFFFFF);
      for (int i = 0; i < 8; i++) send(32'h7FFFFFFF);
      for (int i = 0; i < 6; i++) send(32'h80000000);
      wait_idle();

      // R8: writes while busy and out-of-range writes do nothing
      cur_tag = "R8";
      for (int i = 0; i < NST; i++) wcoef(0, i, 32'h18000000);
      for (int i = 0; i <= NST; i++) wcoef(1, i, 32'h30000000 - i * 32'h08000000);
      send(32'h12345678);
      cfg_we = 1; cfg_sel = 0; cfg_addr = '0; cfg_data = 32'h7FFFFFFF;
      tick(); tick();
      cfg_we = 0;
      wcoef(0, NST, 32'h7FFFFFFF);
      wcoef(1, NST + 1, 32'h7FFFFFFF);
      for (int i = 0; i < 6; i++) send(32'h23456789 - i * 32'h13000000);
      wait_idle();

      // R9: in_valid held high with changing data during a busy period
      cur_tag = "R9";
      for (int i = 0; i < 4; i++) send_hold(32'h05000000 * (i + 1), 32'h7FFFFFFF);
      wait_idle();

      // R6: reset in the middle of a sample
      send(32'h40000000);
      tick(); tick();
      rst = 1;
      tick();
      rst = 0;
      check(in_ready == 1'b1, "R6 in_ready mid", longint'(in_ready), 1);
      check(out_valid == 1'b0, "R6 out_valid mid", longint'(out_valid), 0);
      check(out_data == '0, "R6 out_data mid", longint'(out_data), 0);
      cur_tag = "R6";
      wcoef(1, 0, 32'h7FFFFFFF);
      for (int i = 0; i < 7; i++) send(32'h11111111 * (i + 1));
      wait_idle();
      repeat (4) tick();
      finish_up();
   end

endmodule